// File: doc/BRIEF.md
# Hub Slot Arbiter with Core-0 Fallback

This block decides which processor core owns the shared hub memory bus in each access slot. Slots are handed out in a fixed rotation, one slot per core, and each slot lasts a parameterised number of clock cycles (two by default). When the core that owns the coming slot is disabled, or a master has paused it, that slot is steered to core 0. Unused bandwidth therefore collects on core 0 without any software involvement, and the rotation cadence seen by every other core stays the same.

The arbiter presents its decision as a registered one-hot grant vector and a binary core index. It also drives a strobe that is high in the first cycle of every slot. Downstream hub logic muxes the winning core's request path with the index, and uses the strobe to know when a new owner takes over. The core count is a parameter. The fallback and the rotation need no change when it is raised above eight, and the count need not be a power of two.

Top module: `hub_slot_arbiter`

## Requirements
- R1: While reset is low and in the first cycle after it is released, `sel_o` is 0, `grant_o` has only bit 0 set and `slot_adv_o` is 0. The first new slot begins SLOT_CYCLES cycles after reset is released. When SLOT_CYCLES is 1, it begins at once.
- R2: `slot_adv_o` is high for one cycle at the start of each slot, and consecutive pulses are exactly SLOT_CYCLES cycles apart.
- R3: `sel_o` and `grant_o` change only in cycles where `slot_adv_o` is high.
- R4: Slot owners follow the order 1, 2, …, NUM_CORES-1, 0, 1, … starting from slot 0 at reset. An owner that is enabled and not paused gets its own slot (`sel_o` equals the owner).
- R5: A slot whose owner has its `core_en_i` bit low, as sampled at the clock edge that opens the slot, is granted to core 0.
- R6: A slot whose owner has its `core_pause_i` bit high is granted to core 0. Once the pause bit is cleared, that core's slots return to it from the next rotation.
- R7: Core 0 counts as always enabled. Its bits of `core_en_i` and `core_pause_i` have no effect, and core 0 always receives its own slot.
- R8: `grant_o` always has exactly one bit set, and that bit is at position `sel_o`.
- R9: Over whole rotations, each eligible core other than 0 gets one slot per rotation. Core 0 gets one slot plus one for every ineligible core. With only the odd-numbered cores enabled, core 0 gets half of all slots.
- R10: The same behaviour holds when NUM_CORES is above eight and not a power of two, and when SLOT_CYCLES is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| core_en_i | input | NUM_CORES | Per-core enable, bit i for core i |
| core_pause_i | input | NUM_CORES | Per-core pause from a master, bit i for core i |
| grant_o | output | NUM_CORES | One-hot grant of the current slot |
| sel_o | output | $clog2(NUM_CORES) | Index of the granted core |
| slot_adv_o | output | 1 | High in the first cycle of each slot |

## Verification
Two instances run side by side: eight cores with two-cycle slots, and twelve cores with one-cycle slots. Each runs against a behavioural model compared every cycle. The enable/pause patterns are: all cores enabled, which shows an unbiased rotation; only odd cores enabled, which separates fallback from skipping because core 0 must land at exactly half; only core 0 enabled; a pause on two otherwise enabled cores followed by its release, which shows that pause acts like disable and can be undone; and core 0's own bits cleared or set, which must change nothing. Per-core slot counts over whole rotations are checked against the expected share for each pattern.

// File: rtl/hub_arb_pkg.sv
package hub_arb_pkg;

   // Width of an index able to name n distinct items (at least 1 bit)
   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/hub_slot_timer.sv
// Slot timer: produces the cycle in which the current slot ends.
module hub_slot_timer #(
   parameter int SLOT_CYCLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic slot_end
);
   import hub_arb_pkg::*;

   localparam int PH_W = idx_width(SLOT_CYCLES);

   generate
      if (SLOT_CYCLES < 1) begin : g_bad_cycles
         $error("hub_slot_timer: SLOT_CYCLES must be at least 1");
      end

      if (SLOT_CYCLES == 1) begin : g_single
         // Every cycle closes a slot
         assign slot_end = 1'b1;
      end else begin : g_multi
         localparam logic [PH_W-1:0] PH_LAST = PH_W'(SLOT_CYCLES - 1);
         logic [PH_W-1:0] phase_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               phase_q <= '0;
            end else if (phase_q == PH_LAST) begin
               phase_q <= '0;
            end else begin
               phase_q <= phase_q + PH_W'(1);
            end
         end

         assign slot_end = (phase_q == PH_LAST);

         AST_SLOT_END_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
            slot_end |=> !slot_end); // R2
      end
   endgenerate

endmodule

// File: rtl/hub_slot_sequencer.sv
// Rotation pointer: holds the owner of the current slot and the owner of the next one.
module hub_slot_sequencer #(
   parameter int NUM_CORES = 8
) (
   input  logic                                       clk,
   input  logic                                       rst_n,
   input  logic                                       advance,
   output logic [hub_arb_pkg::idx_width(NUM_CORES)-1:0] owner_now,
   output logic [hub_arb_pkg::idx_width(NUM_CORES)-1:0] owner_next
);
   import hub_arb_pkg::*;

   localparam int IDX_W = idx_width(NUM_CORES);
   localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(NUM_CORES - 1);

   logic [IDX_W-1:0] slot_q;

   // Explicit wrap so that non power-of-two core counts rotate correctly
   assign owner_next = (slot_q == LAST_SLOT) ? '0 : slot_q + IDX_W'(1);
   assign owner_now  = slot_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_q <= '0;
      end else if (advance) begin
         slot_q <= owner_next;
      end
   end

   AST_ROTATE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && slot_q == LAST_SLOT) |=> (slot_q == '0)); // R4
   AST_ROTATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !advance |=> $stable(slot_q)); // R3

endmodule

// File: rtl/hub_slot_select.sv
// Eligibility and fallback: picks the owner or core 0 and builds the one-hot form.
module hub_slot_select #(
   parameter int NUM_CORES = 8
) (
   input  logic [NUM_CORES-1:0]                         core_en,
   input  logic [NUM_CORES-1:0]                         core_pause,
   input  logic [hub_arb_pkg::idx_width(NUM_CORES)-1:0] owner,
   output logic [hub_arb_pkg::idx_width(NUM_CORES)-1:0] pick_idx,
   output logic [NUM_CORES-1:0]                         pick_onehot
);
   import hub_arb_pkg::*;

   localparam int IDX_W = idx_width(NUM_CORES);

   logic [NUM_CORES-1:0] eligible;
   logic                 owner_ok;

   generate
      for (genvar gi = 0; gi < NUM_CORES; gi++) begin : g_elig
         assign eligible[gi] = core_en[gi] & ~core_pause[gi];
      end
   endgenerate

   // Core 0 is treated as always eligible, whatever its own bits say
   assign owner_ok = (owner == '0) || eligible[owner];
   assign pick_idx = owner_ok ? owner : '0;

   generate
      for (genvar gd = 0; gd < NUM_CORES; gd++) begin : g_decode
         assign pick_onehot[gd] = (pick_idx == IDX_W'(gd));
      end
   endgenerate

endmodule

// File: rtl/hub_slot_arbiter.sv
// Top: hub slot arbiter with fixed rotation and fallback of unusable slots to core 0.
module hub_slot_arbiter #(
   parameter int NUM_CORES   = 8,
   parameter int SLOT_CYCLES = 2
) (
   input  logic                                         clk,
   input  logic                                         rst_n,
   input  logic [NUM_CORES-1:0]                         core_en_i,
   input  logic [NUM_CORES-1:0]                         core_pause_i,
   output logic [NUM_CORES-1:0]                         grant_o,
   output logic [hub_arb_pkg::idx_width(NUM_CORES)-1:0] sel_o,
   output logic                                         slot_adv_o
);
   import hub_arb_pkg::*;

   localparam int IDX_W = idx_width(NUM_CORES);
   localparam logic [NUM_CORES-1:0] GRANT_CORE0 = NUM_CORES'(1);

   generate
      if (NUM_CORES < 2) begin : g_bad_cores
         $error("hub_slot_arbiter: NUM_CORES must be at least 2");
      end
   endgenerate

   logic             slot_end;
   logic [IDX_W-1:0] owner_now;
   logic [IDX_W-1:0] owner_next;
   logic [IDX_W-1:0] pick_idx;
   logic [NUM_CORES-1:0] pick_onehot;

   logic [IDX_W-1:0]     sel_q;
   logic [NUM_CORES-1:0] grant_q;
   logic                 adv_q;

   hub_slot_timer #(.SLOT_CYCLES(SLOT_CYCLES)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .slot_end (slot_end)
   );

   hub_slot_sequencer #(.NUM_CORES(NUM_CORES)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .advance    (slot_end),
      .owner_now  (owner_now),
      .owner_next (owner_next)
   );

   hub_slot_select #(.NUM_CORES(NUM_CORES)) u_sel (
      .core_en     (core_en_i),
      .core_pause  (core_pause_i),
      .owner       (owner_next),
      .pick_idx    (pick_idx),
      .pick_onehot (pick_onehot)
   );

   // Decision for the coming slot is registered at the edge that opens it
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q   <= '0;
         grant_q <= GRANT_CORE0;
         adv_q   <= 1'b0;
      end else begin
         adv_q <= slot_end;
         if (slot_end) begin
            sel_q   <= pick_idx;
            grant_q <= pick_onehot;
         end
      end
   end

   assign sel_o      = sel_q;
   assign grant_o    = grant_q;
   assign slot_adv_o = adv_q;

   AST_SEL_ONLY_ON_ADV: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_adv_o |-> ($stable(sel_o) && $stable(grant_o))); // R3
   AST_GRANT_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(grant_o) == 1); // R8
   AST_GRANT_AT_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      grant_o[sel_o]); // R8
   AST_SEL_OWNER_OR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_o != '0) |-> (sel_o == owner_now)); // R5

endmodule

// File: tb/tb_hub_slot_arbiter.sv
module tb_hub_slot_arbiter;

   localparam int CLK_PERIOD = 10;
   localparam int NA = 8;
   localparam int CA = 2;
   localparam int NB = 12;
   localparam int CB = 1;
   localparam int ROT = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NB-1:0] en   = '0;
   logic [NB-1:0] pz   = '0;

   logic [NA-1:0] grant_a;
   logic [2:0]    sel_a;
   logic          adv_a;
   logic [NB-1:0] grant_b;
   logic [3:0]    sel_b;
   logic          adv_b;

   int checks = 0;
   int fails  = 0;
   bit model_on = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hub_slot_arbiter #(.NUM_CORES(NA), .SLOT_CYCLES(CA)) dut (
      .clk(clk), .rst_n(rst_n), .core_en_i(en[NA-1:0]), .core_pause_i(pz[NA-1:0]),
      .grant_o(grant_a), .sel_o(sel_a), .slot_adv_o(adv_a));

   hub_slot_arbiter #(.NUM_CORES(NB), .SLOT_CYCLES(CB)) dut_wide (
      .clk(clk), .rst_n(rst_n), .core_en_i(en), .core_pause_i(pz),
      .grant_o(grant_b), .sel_o(sel_b), .slot_adv_o(adv_b));

   // Behavioural reference, one per instance
   int  ma_ph, ma_slot, ma_sel;  bit ma_adv;
   int  mb_ph, mb_slot, mb_sel;  bit mb_adv;

   function automatic bit usable(int c, logic [NB-1:0] e, logic [NB-1:0] p);
      return (c == 0) || (e[c] && !p[c]);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         ma_ph = 0; ma_slot = 0; ma_sel = 0; ma_adv = 0;
         mb_ph = 0; mb_slot = 0; mb_sel = 0; mb_adv = 0;
      end else begin
         ma_adv = (ma_ph == CA - 1);
         if (ma_adv) begin
            ma_slot = (ma_slot + 1) % NA;
            ma_sel  = usable(ma_slot, en, pz) ? ma_slot : 0;
         end
         ma_ph = (ma_ph + 1) % CA;
         mb_adv = (mb_ph == CB - 1);
         if (mb_adv) begin
            mb_slot = (mb_slot + 1) % NB;
            mb_sel  = usable(mb_slot, en, pz) ? mb_slot : 0;
         end
         mb_ph = (mb_ph + 1) % CB;
      end
   end

   task automatic check(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // Cycle-by-cycle comparison (R2 R3 R4 R5 R6 R8 R10)
   always @(negedge clk) begin
      if (model_on) begin
         check(adv_a == ma_adv, "R2", "strobe A", adv_a, ma_adv);
         check(int'(sel_a) == ma_sel, "R4", "sel A", sel_a, ma_sel);
         check(grant_a == NA'(1) << ma_sel, "R8", "grant A", grant_a, 1 << ma_sel);
         check(adv_b == mb_adv, "R10", "strobe B", adv_b, mb_adv);
         check(int'(sel_b) == mb_sel, "R10", "sel B", sel_b, mb_sel);
         check(grant_b == NB'(1) << mb_sel, "R10", "grant B", grant_b, 1 << mb_sel);
      end
   end

   function automatic int share(int c, int n, logic [NB-1:0] e, logic [NB-1:0] p, int k);
      int lost = 0;
      if (c != 0) return usable(c, e, p) ? k : 0;
      for (int i = 1; i < n; i++) if (!usable(i, e, p)) lost++;
      return k * (1 + lost);
   endfunction

   task automatic measure(string req, int k);
      int ca[NA];
      int cb[NB];
      int na = 0;
      int nb = 0;
      foreach (ca[i]) ca[i] = 0;
      foreach (cb[i]) cb[i] = 0;
      repeat (3 * NB * CA) @(negedge clk);
      while (na < k * NA || nb < k * NB) begin
         @(negedge clk);
         if (adv_a && na < k * NA) begin ca[sel_a]++; na++; end
         if (adv_b && nb < k * NB) begin cb[sel_b]++; nb++; end
      end
      for (int c = 0; c < NA; c++)
         check(ca[c] == share(c, NA, en, pz, k), req, $sformatf("A core %0d share", c),
               ca[c], share(c, NA, en, pz, k));
      for (int c = 0; c < NB; c++)
         check(cb[c] == share(c, NB, en, pz, k), "R10", $sformatf("B core %0d share", c),
               cb[c], share(c, NB, en, pz, k));
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      en = '1; pz = '0;
      repeat (3) @(negedge clk);
      // R1: reset state
      check(sel_a == 0 && grant_a == NA'(1) && !adv_a, "R1", "reset A sel", sel_a, 0);
      check(sel_b == 0 && grant_b == NB'(1) && !adv_b, "R1", "reset B sel", sel_b, 0);
      rst_n = 1'b1;
      model_on = 1'b1;
      @(negedge clk);
      check(!adv_a && sel_a == 0, "R1", "first cycle A strobe", adv_a, 0);
      check(adv_b && sel_b == 1, "R1", "first cycle B sel", sel_b, 1);
      @(negedge clk);
      check(adv_a && sel_a == 1, "R1", "first slot A sel", sel_a, 1);

      // R9: all enabled, fair rotation
      measure("R9", ROT);
      // R9: only odd cores enabled, core 0 gets half
      en = '0;
      for (int i = 1; i < NB; i += 2) en[i] = 1'b1;
      measure("R9", ROT);
      // R5: only core 0 enabled
      en = '0;
      measure("R5", ROT);
      // R6: pause two enabled cores, then release
      en = '1; pz = '0; pz[3] = 1'b1; pz[5] = 1'b1;
      measure("R6", ROT);
      pz = '0;
      measure("R6", ROT);
      // R7: core 0's own bits have no effect
      en = '1; en[0] = 1'b0; pz[0] = 1'b1;
      measure("R7", ROT);
      en[0] = 1'b1; pz[0] = 1'b0;
      repeat (50) @(negedge clk);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule